// File: doc/BRIEF.md
# Video Bus Phase and Precharge Controller

This block produces the bus-control strobes of a video controller that shares the system bus with a CPU. A free-running 3-bit counter on a master clock eight times the bus rate splits each bus period into the two halves of a 1 MHz clock. Its lower bits supply the phases of a 2 MHz and a 4 MHz clock. These phases are combined with a bus-steal request and a register-write indicator to form five outputs:

- the enable that lets the data pins drive the internal data bus;
- the strobe that precharges the internal data bus;
- the address-enable output that grants the address bus to the CPU;
- the output enable of the controller's own address pins;
- a phase-0 clock output.

The data-pin enable is never active in the first half of a 2 MHz cycle, because the internal bus is being precharged then. A parameter selects one of two timings for the address-pin enable. In the first, the enable reacts at once to the CPU grant being low. In the second, the enable holds off for one 4 MHz period after the grant was last high.

Top module: `vbus_phase_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter returns to 0 and every output (`din_en`, `bus_prechg`, `aec`, `addr_oe`, `phi0_out`) reads 0.
- R2: `bus_prechg` is high exactly when counter bit 1 is 0 and counter bit 0 is 1, which is counter values 1 and 5. It is never high in two consecutive cycles.
- R3: `din_en` equals (phi1 OR (phi2 AND `addr_oe`) OR `reg_wr`) AND counter bit 1. Here phi2 is counter bit 2 and phi1 is its inverse.
- R4: `din_en` and `bus_prechg` are never high in the same cycle.
- R5: `aec` is high exactly when phi2 is high (counter values 4 to 7) and `steal_req` is low.
- R6: With `LAG_ADDR_OE` = 0, `addr_oe` is the inverse of `aec`.
- R7: With `LAG_ADDR_OE` = 1, `addr_oe` is high only when `aec` is low now and was low in each of the previous two master cycles. This is one 4 MHz period. Reset counts as `aec` having been high.
- R8: `phi0_out` equals phi2 as it was one master cycle earlier. After reset it reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, eight ticks per bus period |
| rst_n | input | 1 | Synchronous reset, active low |
| steal_req | input | 1 | Video side wants the bus in this period |
| reg_wr | input | 1 | CPU register write is in progress |
| din_en | output | 1 | Data pins may drive the internal data bus |
| bus_prechg | output | 1 | Precharge strobe for the internal data bus |
| aec | output | 1 | Address bus granted to the CPU |
| addr_oe | output | 1 | Output enable of the controller's address pins |
| phi0_out | output | 1 | Phase-0 clock, phi2 delayed one master cycle |

## Verification
`din_en`, `bus_prechg`, `aec` and the variant-A `addr_oe` are combinational in the counter and the inputs. They are due in the same cycle as a change of input, and one edge after a counter step. `phi0_out` lags phi2 by exactly one master edge. The variant-B `addr_oe` needs two further edges of low grant before it can rise. The bench keeps its own counter, grant history and phase-0 register, all updated at the rising edge. It changes inputs at the falling edge and compares one nanosecond later, so every expected value already includes these register stages. Two instances, one per variant, run on the same stimulus.

// File: rtl/vbus_pkg.sv
// Shared types for the video bus phase controller.
// Assumes the master clock runs eight times the bus rate.
package vbus_pkg;
    // Decoded clock phases for the current master tick.
    typedef struct packed {
        logic ph1;       // first half of the 1 MHz period
        logic ph2;       // second half of the 1 MHz period
        logic h2_first;  // first half of a 2 MHz cycle
        logic q4_second; // second half of a 4 MHz cycle
    } phase_t;
endpackage

// File: rtl/vbus_phase_gen.sv
// Phase generator: a free-running counter on the master clock, decoded into
// 1/2/4 MHz phases, plus a phase-0 output registered one tick after phi2.
// Assumes CNT_W >= 3; the top three counter bits form the phases.
module vbus_phase_gen
    import vbus_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_t ph,
    output logic   phi0_q
);
    localparam int HI = CNT_W - 1;

    logic [CNT_W-1:0] cnt;

    // Advance the phase counter every master tick.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end

    // Delay phi2 by one master tick to form phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) phi0_q <= 1'b0;
        else        phi0_q <= cnt[HI];
    end

    // Decode the phases from the counter bits.
    always_comb begin
        ph.ph2       = cnt[HI];
        ph.ph1       = ~cnt[HI];
        ph.h2_first  = ~cnt[HI-1];
        ph.q4_second = cnt[HI-2];
    end
endmodule

// File: rtl/vbus_addr_enable.sv
// CPU address grant and address-pin enable. Grant is high in phi2 unless the
// video side steals the bus. LAG_OE picks the pin-enable timing: 0 follows the
// grant directly, 1 also needs HOLD ticks of low grant history.
// Assumes reset should look like a recent grant.
module vbus_addr_enable #(
    parameter bit LAG_OE = 1'b1,
    parameter int HOLD   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph2,
    input  logic steal_req,
    output logic aec,
    output logic addr_oe
);
    logic [HOLD-1:0] hist;

    // Grant to the CPU: phi2 and no steal, silent in reset.
    always_comb aec = rst_n & ph2 & ~steal_req;

    // Shift recent grant values into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[HOLD-2:0], aec};
    end

    generate
        if (LAG_OE) begin : g_lag
            // Enable only after a full window of low grant.
            always_comb addr_oe = rst_n & ~aec & ~(|hist);
        end else begin : g_direct
            // Enable whenever the grant is low.
            always_comb addr_oe = rst_n & ~aec;
        end
    endgenerate
endmodule

// File: rtl/vbus_strobe.sv
// Data-bus strobes: the precharge strobe and the data-pin input enable.
// The input enable is blocked in the first half of each 2 MHz cycle, the only
// time precharge can fire, so the two never overlap.
module vbus_strobe
    import vbus_pkg::*;
(
    input  logic   rst_n,
    input  phase_t ph,
    input  logic   addr_oe,
    input  logic   reg_wr,
    output logic   din_en,
    output logic   bus_prechg
);
    // Combine the phases into the two data-bus strobes.
    always_comb begin
        bus_prechg = rst_n & ph.h2_first & ph.q4_second;
        din_en     = rst_n & ~ph.h2_first &
                     (ph.ph1 | (ph.ph2 & addr_oe) | reg_wr);
    end
endmodule

// File: rtl/vbus_phase_ctl.sv
// Top: video bus phase and precharge controller. Wires the phase generator,
// address-enable logic and data-bus strobes. Inputs are sampled on the
// master clock; outputs other than phi0_out are combinational.
module vbus_phase_ctl
    import vbus_pkg::*;
#(
    parameter bit LAG_ADDR_OE = 1'b1,
    parameter int CNT_W       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic steal_req,
    input  logic reg_wr,
    output logic din_en,
    output logic bus_prechg,
    output logic aec,
    output logic addr_oe,
    output logic phi0_out
);
    localparam int TICKS = 1 << CNT_W;
    localparam int HOLD  = TICKS / 4;

    phase_t ph;

    vbus_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph     (ph),
        .phi0_q (phi0_out)
    );

    vbus_addr_enable #(.LAG_OE(LAG_ADDR_OE), .HOLD(HOLD)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph2       (ph.ph2),
        .steal_req (steal_req),
        .aec       (aec),
        .addr_oe   (addr_oe)
    );

    vbus_strobe u_strobe (
        .rst_n      (rst_n),
        .ph         (ph),
        .addr_oe    (addr_oe),
        .reg_wr     (reg_wr),
        .din_en     (din_en),
        .bus_prechg (bus_prechg)
    );
endmodule

// File: rtl/vbus_phase_ctl_chk.sv
// Checker for vbus_phase_ctl, bound to every instance of it.
module vbus_phase_ctl_chk #(
    parameter bit LAG_ADDR_OE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic steal_req,
    input logic din_en,
    input logic bus_prechg,
    input logic aec,
    input logic addr_oe,
    input logic phi0_out
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!din_en && !bus_prechg && !aec && !addr_oe);
        end
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_en && bus_prechg));

    // R2
    prechg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_prechg |=> !bus_prechg);

    // R5
    aec_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aec |-> !steal_req);

    // R8
    phi0_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aec && $past(aec)) |-> phi0_out);

    generate
        if (LAG_ADDR_OE) begin : g_lag
            // R7
            oe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(addr_oe) |-> (!$past(aec) && !$past(aec, 2)));
        end else begin : g_direct
            // R6
            oe_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
                addr_oe != aec);
        end
    endgenerate
endmodule

bind vbus_phase_ctl vbus_phase_ctl_chk #(.LAG_ADDR_OE(LAG_ADDR_OE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .steal_req  (steal_req),
    .din_en     (din_en),
    .bus_prechg (bus_prechg),
    .aec        (aec),
    .addr_oe    (addr_oe),
    .phi0_out   (phi0_out)
);

// File: tb/vbus_phase_ctl_bench.sv
module vbus_phase_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic steal_req = 1'b0;
    logic reg_wr = 1'b0;
    logic din_b, pre_b, aec_b, oe_b, p0_b;
    logic din_a, pre_a, aec_a, oe_a, p0_a;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vbus_phase_ctl #(.LAG_ADDR_OE(1'b1)) u_vbus_phase_ctl (
        .clk(clk), .rst_n(rst_n), .steal_req(steal_req), .reg_wr(reg_wr),
        .din_en(din_b), .bus_prechg(pre_b), .aec(aec_b), .addr_oe(oe_b),
        .phi0_out(p0_b));

    vbus_phase_ctl #(.LAG_ADDR_OE(1'b0)) u_vbus_phase_ctl_va (
        .clk(clk), .rst_n(rst_n), .steal_req(steal_req), .reg_wr(reg_wr),
        .din_en(din_a), .bus_prechg(pre_a), .aec(aec_a), .addr_oe(oe_a),
        .phi0_out(p0_a));

    // Reference state, built from the requirements.
    logic [2:0] m = 3'd0;
    logic h1 = 1'b1, h2 = 1'b1, p0m = 1'b0;

    function automatic logic f_aec(logic r, logic [2:0] c, logic s);
        return r & c[2] & ~s;
    endfunction

    function automatic logic f_din(logic r, logic [2:0] c, logic oe, logic w);
        return r & c[1] & (~c[2] | (c[2] & oe) | w);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m <= 3'd0; h1 <= 1'b1; h2 <= 1'b1; p0m <= 1'b0;
        end else begin
            m <= m + 3'd1;
            p0m <= m[2];
            h1 <= f_aec(rst_n, m, steal_req);
            h2 <= h1;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(logic s, logic w, logic r);
        logic ea, eoa, eob, epre;
        @(negedge clk);
        steal_req = s; reg_wr = w; rst_n = r;
        #1;
        ea   = f_aec(rst_n, m, steal_req);
        eoa  = rst_n & ~ea;
        eob  = rst_n & ~ea & ~h1 & ~h2;
        epre = rst_n & ~m[1] & m[0];
        if (!rst_n) begin
            chk("R1", "din_en", din_b, 1'b0);
            chk("R1", "aec", aec_b, 1'b0);
            chk("R1", "addr_oe", oe_b, 1'b0);
            chk("R1", "bus_prechg", pre_a, 1'b0);
        end
        chk("R2", "bus_prechg", pre_b, epre);
        chk("R2", "bus_prechg_a", pre_a, epre);
        chk("R5", "aec", aec_b, ea);
        chk("R5", "aec_a", aec_a, ea);
        chk("R6", "addr_oe_a", oe_a, eoa);
        chk("R7", "addr_oe_b", oe_b, eob);
        chk("R3", "din_en_b", din_b, f_din(rst_n, m, eob, reg_wr));
        chk("R3", "din_en_a", din_a, f_din(rst_n, m, eoa, reg_wr));
        chk("R4", "overlap", din_b & pre_b, 1'b0);
        chk("R8", "phi0_out", p0_b, p0m);
        chk("R8", "phi0_out_a", p0_a, p0m);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);   // R1 reset
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b1);  // quiet bus
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1);  // steal held
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b1);  // write held
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b1);  // both held
        for (int i = 0; i < 2000; i++)
            step(1'($urandom % 2), 1'($urandom % 2), 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0);   // R1 mid-run reset
        for (int i = 0; i < 1000; i++)
            step(1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule